// File: doc/BRIEF.md
# Compact Timer with Compare-Match and PWM Output

This block is a 10-bit up-counting timer. It advances by one on every clock in which its tick input is high while it is enabled. It has two comparators. The period comparator holds a 3-bit value and looks only at the counter's three most significant bits, so its periods are whole multiples of 128 ticks. Comparator A holds a full 10-bit value. Control fields arrive on plain input ports and select one of three operating modes:

- **Compare-match output:** a comparator A hit drives the pin low, drives it high, toggles it, or leaves it alone.
- **PWM output:** one comparator sets the period and the other sets the duty.
- **Timer/counter:** the pin only holds its initial level.

In every mode a select bit chooses which comparator clears the counter. A polarity bit inverts the pin in the two output modes. Each comparator raises a one-clock hit flag.

The enable bit starts the timer. When it is low, the counter sits at zero. When it rises, the pin reloads with the programmed initial level. The mode field is meant to be changed only while the timer is disabled.

Top module: `cmp_pwm_timer`

## Requirements
- R1: In timer/counter or compare-match mode with the clear select at 0, the counter clears after the tick on which it equals P×128−1, where P is the 3-bit period value taken modulo 1024. This gives a period of P×128 ticks for P=1..7 and 1024 ticks for P=0.
- R2: In timer/counter or compare-match mode with the clear select at 1, the counter clears after the tick on which it equals the comparator A value V. This gives a period of V+1 ticks.
- R3: Each hit flag is high for exactly one clock. The flag rises in the clock after an enabled tick on which the counter met its compare point: A when the counter equals V, P when it equals P×128−1. The flags never rise while the timer is disabled.
- R4: The counter changes only on clocks where the tick input is high. With a tick every third clock, a P=1 period lasts 384 clocks.
- R5: The mode field is decoded as follows: 00 selects compare-match, 10 selects PWM, and 11 selects timer/counter. Code 01 behaves as timer/counter.
- R6: In compare-match mode, a comparator A hit applies the pin-action field: 00 keeps the level, 01 drives it low, 10 drives it high, 11 toggles it. Requesting the level the pin already has leaves the pin unchanged.
- R7: In compare-match or PWM mode, the clock after the enable bit rises, the pin shows the initial-level bit XOR the polarity bit.
- R8: In PWM mode with pin-action 10, the pin is active while the counter is below the duty value, and the period comparator clears the counter. With duty/period select 0, the period comes from P and the duty is V. With select 1, the period comes from A (V+1 ticks) and the duty is P×128. The active fraction per period is therefore min(duty, period).
- R9: In PWM mode, pin-action 00 holds the pin at its inactive level, and 11 does the same. Pin-action 01 holds it at its active level.
- R10: In the output modes, the pin is 1 when active and 0 when inactive, XORed with the polarity bit. In timer/counter mode, the pin equals the initial-level bit and the polarity bit has no effect.
- R11: While the enable bit is low, the counter is held at zero, no hit flag rises, and the pin keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable; the counter advances one step per high cycle |
| run | input | 1 | Timer enable |
| mode | input | 2 | Operating mode (00 compare, 10 PWM, 11 or 01 timer) |
| pin_act | input | 2 | Pin action, decoded per mode |
| init_lvl | input | 1 | Initial pin level |
| pol_inv | input | 1 | Output polarity invert |
| swap_src | input | 1 | PWM select: 0 = P period and A duty, 1 = A period and P duty |
| clr_sel | input | 1 | Counter clear source: 0 = P hit, 1 = A hit |
| per_val | input | 3 | Period comparator value |
| cmpa_val | input | 10 | Comparator A value |
| pin_out | output | 1 | Output pin level |
| a_hit | output | 1 | One-clock comparator A hit flag |
| p_hit | output | 1 | One-clock period comparator hit flag |

## Verification
The period comparator is swept over all eight codes, so the 1024-tick zero code is kept apart from the 128-tick multiples. Comparator A clearing is tried at 5, 300 and 1023, which separates an off-by-one in the clear point from a wrap error. Compare-match runs every pin action against both initial levels and both polarities, so a "same level" request is told apart from a real drive and from a toggle. PWM duty is measured over whole periods at zero, one, half, one-below-full and over-full duty, and with the period and duty sources swapped. Forced levels, timer-mode holding, a sparse tick and a disabled timer are each checked at the pin and the flags.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [1:0] {
    MODE_CMP = 2'b00,
    MODE_RSV = 2'b01,
    MODE_PWM = 2'b10,
    MODE_TMR = 2'b11
  } tmr_mode_e;

  localparam logic [1:0] ACT_KEEP = 2'b00;
  localparam logic [1:0] ACT_LOW  = 2'b01;
  localparam logic [1:0] ACT_HIGH = 2'b10;
  localparam logic [1:0] ACT_TOG  = 2'b11;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (tick) begin
      if (clr) cnt_d = '0;
      else     cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int CNT_W = 10,
  parameter int PER_W = 3
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [PER_W-1:0] per_val,
  input  logic [CNT_W-1:0] cmpa_val,
  output logic             a_eq,
  output logic             p_eq,
  output logic [CNT_W-1:0] p_top
);
  localparam int SHIFT = CNT_W - PER_W;

  // P boundary: the last count before the top bits would reach per_val.
  // A zero code wraps to the full-scale count.
  assign p_top = {per_val, {SHIFT{1'b0}}};
  assign p_eq  = (cnt == (p_top - CNT_W'(1)));
  assign a_eq  = (cnt == cmpa_val);
endmodule

// File: rtl/tmr_pin.sv
module tmr_pin
  import timer_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_mode_e        mode,
  input  logic [1:0]       pin_act,
  input  logic             init_lvl,
  input  logic             pol_inv,
  input  logic             swap_src,
  input  logic             run,
  input  logic             run_rise,
  input  logic             tick,
  input  logic             a_eq,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmpa_val,
  input  logic [CNT_W-1:0] p_top,
  output logic             pin_out
);
  logic             raw_d;
  logic             raw_q;
  logic             out_mode;
  logic [CNT_W-1:0] duty;
  logic             pwm_lvl;

  assign out_mode = (mode == MODE_CMP) || (mode == MODE_PWM);
  assign duty     = swap_src ? p_top : cmpa_val;
  assign pwm_lvl  = (cnt < duty);

  always_comb begin
    raw_d = raw_q;
    if (!out_mode) begin
      raw_d = init_lvl;
    end else if (run_rise) begin
      raw_d = init_lvl;
    end else if (run) begin
      if (mode == MODE_CMP) begin
        if (tick && a_eq) begin
          case (pin_act)
            ACT_LOW:  raw_d = 1'b0;
            ACT_HIGH: raw_d = 1'b1;
            ACT_TOG:  raw_d = ~raw_q;
            default:  raw_d = raw_q;
          endcase
        end
      end else begin
        case (pin_act)
          2'b00:   raw_d = 1'b0;
          2'b01:   raw_d = 1'b1;
          2'b10:   raw_d = pwm_lvl;
          default: raw_d = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= 1'b0;
    else        raw_q <= raw_d;
  end

  assign pin_out = raw_q ^ (pol_inv & out_mode);
endmodule

// File: rtl/cmp_pwm_timer.sv
module cmp_pwm_timer
  import timer_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int PER_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic [1:0]       mode,
  input  logic [1:0]       pin_act,
  input  logic             init_lvl,
  input  logic             pol_inv,
  input  logic             swap_src,
  input  logic             clr_sel,
  input  logic [PER_W-1:0] per_val,
  input  logic [CNT_W-1:0] cmpa_val,
  output logic             pin_out,
  output logic             a_hit,
  output logic             p_hit
);
  tmr_mode_e        mode_e;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] p_top;
  logic             a_eq;
  logic             p_eq;
  logic             clr;
  logic             use_a;
  logic             run_d;
  logic             run_rise;
  logic             a_hit_d, a_hit_q;
  logic             p_hit_d, p_hit_q;

  assign mode_e   = tmr_mode_e'(mode);
  assign use_a    = (mode_e == MODE_PWM) ? swap_src : clr_sel;
  assign clr      = use_a ? a_eq : p_eq;
  assign run_rise = run & ~run_d;
  assign a_hit_d  = run & tick & a_eq;
  assign p_hit_d  = run & tick & p_eq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_d   <= 1'b0;
      a_hit_q <= 1'b0;
      p_hit_q <= 1'b0;
    end else begin
      run_d   <= run;
      a_hit_q <= a_hit_d;
      p_hit_q <= p_hit_d;
    end
  end

  tmr_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick),
    .clr  (clr),
    .cnt  (cnt_q)
  );

  tmr_match #(.CNT_W(CNT_W), .PER_W(PER_W)) match_i (
    .cnt     (cnt_q),
    .per_val (per_val),
    .cmpa_val(cmpa_val),
    .a_eq    (a_eq),
    .p_eq    (p_eq),
    .p_top   (p_top)
  );

  tmr_pin #(.CNT_W(CNT_W)) pin_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode_e),
    .pin_act (pin_act),
    .init_lvl(init_lvl),
    .pol_inv (pol_inv),
    .swap_src(swap_src),
    .run     (run),
    .run_rise(run_rise),
    .tick    (tick),
    .a_eq    (a_eq),
    .cnt     (cnt_q),
    .cmpa_val(cmpa_val),
    .p_top   (p_top),
    .pin_out (pin_out)
  );

  assign a_hit = a_hit_q;
  assign p_hit = p_hit_q;
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             tick,
  input logic [1:0]       mode,
  input logic             init_lvl,
  input logic             clr_sel,
  input logic [CNT_W-1:0] cnt,
  input logic             a_hit,
  input logic             p_hit,
  input logic             pin_out
);
  logic started_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started_q <= 1'b0;
    else        started_q <= 1'b1;
  end

  // R3
  flag_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_hit || p_hit) |-> $past(run && tick));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run && tick) |-> (cnt == $past(cnt) + CNT_W'(1) || cnt == '0));

  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run && !tick) |-> cnt == $past(cnt));

  // R11
  off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);

  // R1
  p_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_hit && $past(mode != 2'b10 && !clr_sel)) |-> cnt == '0);

  // R2
  a_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_hit && $past(mode != 2'b10 && clr_sel)) |-> cnt == '0);

  // R10
  tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (started_q && mode[0] && $past(mode[0])) |-> pin_out == $past(init_lvl));
endmodule

bind cmp_pwm_timer tmr_chk #(.CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (run),
  .tick    (tick),
  .mode    (mode),
  .init_lvl(init_lvl),
  .clr_sel (clr_sel),
  .cnt     (cnt_q),
  .a_hit   (a_hit),
  .p_hit   (p_hit),
  .pin_out (pin_out)
);

// File: tb/cmp_pwm_timer_tb_top.sv
`timescale 1ns/1ps
module cmp_pwm_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick, run;
  logic [1:0] mode, pin_act;
  logic       init_lvl, pol_inv, swap_src, clr_sel;
  logic [2:0] per_val;
  logic [9:0] cmpa_val;
  logic       pin_out, a_hit, p_hit;
  logic       sparse;
  int         phase;
  int         errors = 0;
  int         checks = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  cmp_pwm_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .mode(mode),
    .pin_act(pin_act), .init_lvl(init_lvl), .pol_inv(pol_inv),
    .swap_src(swap_src), .clr_sel(clr_sel), .per_val(per_val),
    .cmpa_val(cmpa_val), .pin_out(pin_out), .a_hit(a_hit), .p_hit(p_hit)
  );

  // tick generator: every clock, or every third clock when sparse
  always @(negedge clk) begin
    if (!sparse) begin
      tick  <= 1'b1;
      phase <= 0;
    end else begin
      tick  <= (phase == 2);
      phase <= (phase == 2) ? 0 : phase + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // cycles between two successive flag pulses (sel 0: P, 1: A)
  task automatic interval(input bit sel, output int iv);
    int n = 0;
    while (!(sel ? a_hit : p_hit) && n < 5000) begin @(negedge clk); n++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!(sel ? a_hit : p_hit) && n < 5000);
    iv = n;
  endtask

  task automatic wait_a(output bit seen);
    int n = 0;
    do begin @(negedge clk); n++; end while (!a_hit && n < 3000);
    seen = a_hit;
  endtask

  task automatic stop_run();
    run = 1'b0;
    cyc(3);
  endtask

  initial begin
    #(20ns * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int iv;
    int cnt1;
    bit seen;
    int bad;
    bit init_v, pol_v;
    int duties[5];
    int sw_p[3];
    sparse = 0; phase = 0; tick = 1'b1;
    rst_n = 1'b0; run = 1'b0; mode = 2'b11; pin_act = 2'b00;
    init_lvl = 1'b0; pol_inv = 1'b0; swap_src = 1'b0; clr_sel = 1'b0;
    per_val = 3'd1; cmpa_val = 10'd0;
    cyc(4);
    chk(pin_out == 1'b0 && a_hit == 1'b0 && p_hit == 1'b0, "reset", pin_out, 0);
    rst_n = 1'b1;
    cyc(2);

    // R1: period sweep over all P codes in timer mode
    for (int p = 0; p < 8; p++) begin
      stop_run();
      mode = 2'b11; clr_sel = 1'b0; per_val = 3'(p); cmpa_val = 10'd1000;
      run = 1'b1;
      interval(1'b0, iv);
      chk(iv == ((p == 0) ? 1024 : p * 128), "R1 period", iv, (p == 0) ? 1024 : p * 128);
    end
    // R3: single-clock width of P flag
    while (!p_hit) @(negedge clk);
    @(negedge clk);
    chk(p_hit == 1'b0, "R3 p width", p_hit, 0);

    // R2: A clears the counter
    begin
      int avals[3] = '{5, 300, 1023};
      for (int k = 0; k < 3; k++) begin
        stop_run();
        clr_sel = 1'b1; per_val = 3'd1; cmpa_val = 10'(avals[k]);
        run = 1'b1;
        interval(1'b1, iv);
        chk(iv == avals[k] + 1, "R2 A period", iv, avals[k] + 1);
      end
    end
    while (!a_hit) @(negedge clk);
    @(negedge clk);
    chk(a_hit == 1'b0, "R3 a width", a_hit, 0);

    // R3: A flag lands at the expected distance from the start
    stop_run();
    clr_sel = 1'b0; per_val = 3'd2; cmpa_val = 10'd40;
    run = 1'b1;
    iv = 0;
    do begin @(negedge clk); iv++; end while (!a_hit && iv < 3000);
    chk(iv == 41, "R3 A timing", iv, 41);

    // R4: sparse tick stretches the period
    stop_run();
    per_val = 3'd1; clr_sel = 1'b0; sparse = 1;
    run = 1'b1;
    interval(1'b0, iv);
    chk(iv == 384, "R4 sparse tick", iv, 384);
    sparse = 0;

    // R6 / R7 / R10: compare-match actions for each init and polarity
    for (int act = 0; act < 4; act++) begin
      for (int iv2 = 0; iv2 < 2; iv2++) begin
        for (int pv = 0; pv < 2; pv++) begin
          int e1, e2;
          stop_run();
          init_v = iv2[0]; pol_v = pv[0];
          mode = 2'b00; pin_act = 2'(act); init_lvl = init_v; pol_inv = pol_v;
          clr_sel = 1'b0; per_val = 3'd1; cmpa_val = 10'd10;
          run = 1'b1;
          @(negedge clk);
          chk(pin_out == (init_v ^ pol_v), "R7 reload", pin_out, init_v ^ pol_v);
          case (act)
            0: begin e1 = init_v; e2 = init_v; end
            1: begin e1 = 0; e2 = 0; end
            2: begin e1 = 1; e2 = 1; end
            default: begin e1 = !init_v; e2 = init_v; end
          endcase
          wait_a(seen);
          chk(seen && pin_out == (e1[0] ^ pol_v), "R6 first hit", pin_out, e1 ^ pv);
          wait_a(seen);
          chk(seen && pin_out == (e2[0] ^ pol_v), "R6 second hit", pin_out, e2 ^ pv);
        end
      end
    end

    // R11: disabled timer holds pin, no flags
    begin
      logic held;
      held = pin_out;
      run = 1'b0;
      bad = 0;
      for (int i = 0; i < 1500; i++) begin
        @(negedge clk);
        if (a_hit || p_hit || pin_out != held) bad++;
      end
      chk(bad == 0, "R11 disabled", bad, 0);
    end

    // R8: PWM duty, P period, A duty
    duties = '{0, 1, 64, 127, 200};
    for (int pv = 0; pv < 2; pv++) begin
      for (int k = 0; k < 5; k++) begin
        int exp;
        stop_run();
        mode = 2'b10; pin_act = 2'b10; swap_src = 1'b0; pol_inv = pv[0];
        init_lvl = 1'b0; per_val = 3'd1; cmpa_val = 10'(duties[k]);
        run = 1'b1;
        cyc(300);
        cnt1 = 0;
        for (int i = 0; i < 128; i++) begin @(negedge clk); if (pin_out) cnt1++; end
        exp = (duties[k] > 128) ? 128 : duties[k];
        if (pv == 1) exp = 128 - exp;
        chk(cnt1 == exp, (pv == 0) ? "R8 duty" : "R10 pwm inverted", cnt1, exp);
      end
    end

    // R8: swapped sources, A period, P*128 duty
    sw_p = '{1, 2, 3};
    for (int k = 0; k < 3; k++) begin
      int exp;
      stop_run();
      mode = 2'b10; pin_act = 2'b10; swap_src = 1'b1; pol_inv = 1'b0;
      per_val = 3'(sw_p[k]); cmpa_val = 10'd299;
      run = 1'b1;
      cyc(700);
      cnt1 = 0;
      for (int i = 0; i < 300; i++) begin @(negedge clk); if (pin_out) cnt1++; end
      exp = (sw_p[k] * 128 > 300) ? 300 : sw_p[k] * 128;
      chk(cnt1 == exp, "R8 swapped", cnt1, exp);
    end

    // R9: forced PWM levels
    for (int act = 0; act < 4; act++) begin
      int expl;
      if (act == 2) continue;
      for (int pv = 0; pv < 2; pv++) begin
        stop_run();
        mode = 2'b10; pin_act = 2'(act); swap_src = 1'b0; pol_inv = pv[0];
        per_val = 3'd1; cmpa_val = 10'd64;
        run = 1'b1;
        cyc(2);
        expl = ((act == 1) ? 1 : 0) ^ pv;
        bad = 0;
        for (int i = 0; i < 300; i++) begin @(negedge clk); if (pin_out != expl[0]) bad++; end
        chk(bad == 0, "R9 forced level", bad, 0);
      end
    end

    // R5 / R10: timer codes 11 and 01 hold the initial level, polarity ignored
    for (int m = 0; m < 2; m++) begin
      for (int iv3 = 0; iv3 < 2; iv3++) begin
        stop_run();
        mode = (m == 0) ? 2'b11 : 2'b01; init_lvl = iv3[0]; pol_inv = 1'b1;
        pin_act = 2'b11; cmpa_val = 10'd3; per_val = 3'd1;
        run = 1'b1;
        cyc(2);
        bad = 0;
        for (int i = 0; i < 300; i++) begin @(negedge clk); if (pin_out != iv3[0]) bad++; end
        chk(bad == 0, (m == 0) ? "R10 timer hold" : "R5 code 01", bad, 0);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule